// File: doc/BRIEF.md
# Serial Output Freeze Register

This block lets a controller stop and restart individual divided clock outputs through a two-wire serial load. A free-running serial clock samples a data line. A low start bit opens a frame, and twelve data bits follow it. When the last data bit arrives, the twelve bits are committed together as a freeze word. Each bit of that word decides whether one clock output toggles or sits parked low.

Every gated output has its own gate cell. The cell carries its freeze bit into that output's clock domain through two flops. The enable that reaches the AND gate changes only on the falling edge of the output's own clock. As a result a pulse is either passed whole or not at all.

Two outputs, bank C output 0 and the feedback output, pass straight through and cannot be frozen.

The receiver is a two-state machine:
- **RX_IDLE**: the line is high and no frame is in progress.
- **RX_SHIFT**: data bits are being collected.

It has three transitions:
- **start**: RX_IDLE to RX_SHIFT, on a low sample.
- **collect**: RX_SHIFT to RX_SHIFT, while fewer than twelve data bits have been taken.
- **commit**: RX_SHIFT to RX_IDLE, on the twelfth data bit. The word is loaded on this transition.

Top module: `freeze_gate_ctrl`

## Requirements
- R1: While the receiver is idle and the data line is sampled high, it stays idle and the freeze word does not change.
- R2: The receiver samples the data line on rising serial clock edges. A low sample while idle is a start bit. The next twelve samples are data bits, with D0 first and D11 last.
- R3: The freeze word changes only on the edge that samples D11, and all twelve bits change on that edge. The receiver is idle right after that edge, so a start bit on the very next sample is accepted.
- R4: After reset, all twelve freeze bits are 1 and every output toggles with its source.
- R5: Bits D0 to D3 control out_a[0] to out_a[3]. Bits D4 to D7 control out_b[0] to out_b[3]. Bits D8 to D10 control out_c[1] to out_c[3]. Bit D11 controls out_sync.
- R6: A freeze bit of 0 holds its output at logic 0. A freeze bit of 1 lets the output follow its source clock.
- R7: out_c[0] always equals src_c[0], and out_fb always equals src_fb, whatever the freeze word.
- R8: A gated output is high only while its source is high. Every high phase it produces is a complete high phase of the source, so no runt pulse appears when an output is frozen or released.
- R9: A freeze bit passes through two flops clocked by the rising edge of its output's clock, then reaches the gate on the following falling edge. The new setting therefore holds within three periods of that output's clock after the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Free-running serial clock |
| sdin | input | 1 | Serial data, idle high |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 4 | Bank A source clocks |
| src_b | input | 4 | Bank B source clocks |
| src_c | input | 4 | Bank C source clocks |
| src_sync | input | 1 | Sync source clock |
| src_fb | input | 1 | Feedback source clock |
| out_a | output | 4 | Gated bank A clocks |
| out_b | output | 4 | Gated bank B clocks |
| out_c | output | 4 | Bank C clocks; bit 0 is never gated |
| out_sync | output | 1 | Gated sync clock |
| out_fb | output | 1 | Feedback clock, never gated |

## Verification
Some behaviour is checked on every cycle. In the receiver, that covers: the idle hold on a high line, the start-bit entry with a cleared bit counter, the word staying unchanged in mid-frame, and the commit of D11 on the return to idle. In every gate cell, it covers two things: the output is low before each source rise, and the level during each high phase matches the synchronised bit from one falling edge earlier. Other behaviour only the bench scenarios can show. That includes the bit-to-output map, parking low, and the untouched ungated outputs. It also includes whole pulses across freeze and release, observed by measuring high-phase widths against each source's half period, and back-to-back frames with no idle gap.

// File: rtl/frzctl_pkg.sv
package frzctl_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Receiver states
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;
endpackage

// File: rtl/frz_serial_rx.sv
module frz_serial_rx
    import frzctl_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdin,
    output logic [WORD_W-1:0] word_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-2:0] shift_q;
    logic [WORD_W-1:0] word_q;
    logic              shift_en, commit;

    // State register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (!sdin) state_d = RX_SHIFT;             // start
            end
            RX_SHIFT: begin
                if (cnt_q == LAST_BIT) begin               // commit
                    commit  = 1'b1;
                    state_d = RX_IDLE;
                end else begin                              // collect
                    shift_en = 1'b1;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // Data path: bits arrive D0 first and move toward bit 0
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
            word_q  <= '1;
        end else begin
            if (shift_en) begin
                shift_q <= {sdin, shift_q[WORD_W-2:1]};
                cnt_q   <= cnt_q + 1'b1;
            end
            if (commit) begin
                word_q <= {sdin, shift_q};
                cnt_q  <= '0;
            end
        end
    end

    assign word_o = word_q;

    // R1: high line while idle keeps the receiver idle and the word unchanged
    p_idle_hold_r1: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == RX_IDLE && sdin) |=> (state_q == RX_IDLE && $stable(word_q)));

    // R2: a low sample while idle starts a frame at bit 0
    p_start_r2: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == RX_IDLE && !sdin) |=> (state_q == RX_SHIFT && cnt_q == '0));

    // R3: no change of the word inside a frame
    p_atomic_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == RX_SHIFT && cnt_q != LAST_BIT) |=> $stable(word_q));

    // R3: last data bit lands in the top bit, receiver back to idle
    p_commit_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == RX_SHIFT && cnt_q == LAST_BIT)
        |=> (state_q == RX_IDLE && word_q[WORD_W-1] == $past(sdin)));
endmodule

// File: rtl/frz_gate_cell.sv
module frz_gate_cell (
    input  logic clk_src,
    input  logic rst_n,
    input  logic enable_i,
    output logic clk_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic sync1_q, sync2_q, en_q;

    // Two-flop synchronizer into this output's domain
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= enable_i;
            sync2_q <= sync1_q;
        end
    end

    // Enable moves only on the falling edge, while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= sync2_q;
    end

    assign clk_o = clk_src & en_q;

    // R8: the output is low in the low phase that precedes each rise
    p_low_phase_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
        !clk_o);

    // R9: the high phase just ending reflects the synchronised bit of one falling edge earlier
    p_gate_follow_r9: assert property (@(negedge clk_src) disable iff (!rst_n)
        clk_o == $past(sync2_q));
endmodule

// File: rtl/freeze_gate_ctrl.sv
module freeze_gate_ctrl #(
    parameter int BANK_W = 4
) (
    input  logic              sclk,
    input  logic              sdin,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src_a,
    input  logic [BANK_W-1:0] src_b,
    input  logic [BANK_W-1:0] src_c,
    input  logic              src_sync,
    input  logic              src_fb,
    output logic [BANK_W-1:0] out_a,
    output logic [BANK_W-1:0] out_b,
    output logic [BANK_W-1:0] out_c,
    output logic              out_sync,
    output logic              out_fb
);
    timeunit 1ns;
    timeprecision 1ps;

    // A bank, B bank, C bank minus output 0, plus sync
    localparam int WORD_W = 3 * BANK_W;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] gsrc;
    logic [WORD_W-1:0] gout;

    frz_serial_rx #(.WORD_W(WORD_W)) u_rx (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .sdin   (sdin),
        .word_o (word)
    );

    // Word bit order fixes the output map
    assign gsrc = {src_sync, src_c[BANK_W-1:1], src_b, src_a};

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_gate
        frz_gate_cell u_cell (
            .clk_src  (gsrc[gi]),
            .rst_n    (rst_n),
            .enable_i (word[gi]),
            .clk_o    (gout[gi])
        );
    end

    assign out_a    = gout[BANK_W-1:0];
    assign out_b    = gout[2*BANK_W-1:BANK_W];
    assign out_c    = {gout[3*BANK_W-2:2*BANK_W], src_c[0]};
    assign out_sync = gout[WORD_W-1];
    assign out_fb   = src_fb;
endmodule

// File: tb/freeze_gate_ctrl_bench.sv
module freeze_gate_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NOUT = 14;

    logic sclk = 1'b0;
    logic sdin = 1'b1;
    logic rst_n = 1'b0;
    logic [NOUT-1:0] srcv;
    logic [NOUT-1:0] outv;
    logic [3:0] out_a, out_b, out_c;
    logic out_sync, out_fb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 sclk = ~sclk;   // 250 MHz

    // Output index i has half period 3+i ns; 8 = C0 (free), 13 = feedback (free)
    for (genvar g = 0; g < NOUT; g++) begin : g_src
        logic c = 1'b0;
        initial forever #(3 + g) c = ~c;
        assign srcv[g] = c;
    end

    freeze_gate_ctrl u_freeze_gate_ctrl (
        .sclk(sclk), .sdin(sdin), .rst_n(rst_n),
        .src_a(srcv[3:0]), .src_b(srcv[7:4]), .src_c(srcv[11:8]),
        .src_sync(srcv[12]), .src_fb(srcv[13]),
        .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .out_sync(out_sync), .out_fb(out_fb)
    );

    assign outv = {out_fb, out_sync, out_c, out_b, out_a};

    // Expected activity of output idx under freeze word w (R5 map, R7 free outputs)
    function automatic bit exp_active(logic [11:0] w, int idx);
        if (idx < 8)                return w[idx];
        else if (idx == 8 || idx == 13) return 1'b1;
        else if (idx < 12)          return w[idx-1];
        else                        return w[11];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(logic [11:0] w, bit trail_idle);
        @(negedge sclk) sdin = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge sclk) sdin = w[k];
        end
        if (trail_idle) @(negedge sclk) sdin = 1'b1;
    endtask

    // Sample every 0.5 ns at quarter offsets, away from all edges
    task automatic observe(int win_ns, logic [11:0] w, bit act, string req);
        int rises [NOUT];
        int runt [NOUT];
        int run [NOUT];
        bit seen_low [NOUT];
        logic [NOUT-1:0] prev, cur, curs;
        #0.25;
        prev = outv;
        for (int i = 0; i < NOUT; i++) begin
            rises[i] = 0; runt[i] = 0; run[i] = 0; seen_low[i] = !prev[i];
        end
        for (int s = 0; s < 2 * win_ns; s++) begin
            #0.5;
            cur = outv;
            curs = srcv;
            for (int i = 0; i < NOUT; i++) begin
                if (cur[i] && !curs[i]) runt[i]++;
                if (cur[i] && !prev[i]) begin
                    rises[i]++;
                    run[i] = 1;
                end else if (cur[i]) begin
                    run[i]++;
                end
                if (!cur[i] && prev[i] && seen_low[i] && run[i] != 2 * (3 + i)) runt[i]++;
                if (!cur[i]) seen_low[i] = 1'b1;
            end
            prev = cur;
        end
        for (int i = 0; i < NOUT; i++) begin
            chk(runt[i] == 0, "R8", $sformatf("runt/high-while-low count out%0d", i), runt[i], 0);
            if (act) begin
                if (exp_active(w, i))
                    chk(rises[i] > 0, (i == 8 || i == 13) ? "R7" : req,
                        $sformatf("rises out%0d word=%03h", i, w), rises[i], 1);
                else
                    chk(rises[i] == 0 && prev[i] == 1'b0, req,
                        $sformatf("parked-low rises out%0d word=%03h", i, w), rises[i], 0);
            end
        end
        @(negedge sclk);
    endtask

    task automatic apply(logic [11:0] w, string req);
        send_frame(w, 1'b1);
        observe(100, w, 1'b0, "R8");   // transition window, pulse integrity only
        observe(150, w, 1'b1, req);
    endtask

    initial begin
        logic [11:0] w;
        void'($urandom(32'h5eed_1234));
        #21 rst_n = 1'b1;
        @(negedge sclk);
        // R4: everything enabled after reset
        observe(150, 12'hFFF, 1'b1, "R4");
        // R1: long idle-high stretch changes nothing
        repeat (100) @(negedge sclk);
        observe(150, 12'hFFF, 1'b1, "R1");
        // R6: freeze all, then release all
        apply(12'h000, "R6");
        apply(12'hFFF, "R6");
        // R5: walking zero over the bit map
        for (int k = 0; k < 12; k++) apply(~(12'h001 << k), "R5");
        // R2: mixed patterns with zeros inside the frame
        apply(12'hA5C, "R2");
        apply(12'h3F0, "R2");
        // R3: back-to-back frames, second start bit right after D11
        send_frame(12'h000, 1'b0);
        send_frame(12'h5A5, 1'b1);
        observe(100, 12'h5A5, 1'b0, "R8");
        observe(150, 12'h5A5, 1'b1, "R3");
        // R9: random words, settled within three slowest periods
        for (int n = 0; n < 8; n++) begin
            w = 12'($urandom);
            apply(w, "R9");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule